// File: doc/BRIEF.md
# Dual-Source Interrupt Router

This block merges two interrupt sources onto the two interrupt lines of a processor. The first source is the video field-sync signal. A strap input decides where it goes: nowhere, into a latched and maskable status bit, or straight onto the non-maskable line as a single one-cycle pulse per frame. The second source is a completion strobe from a host-service peripheral. It always lands in a latched status bit.

Software sees a 32-byte, byte-wide register window on a simple synchronous slave port with no wait states. Three offsets in that window matter: status at 0x11, enable at 0x12 and acknowledge at 0x13. Read data is combinational in the cycle of the access. The port has no back-pressure; every access completes in the cycle it is presented. The maskable output stays high while any enabled status bit is set.

Top module: `irq_route_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, status and enable read zero and `irq_o` and `nmi_o` are low.
- R2: `route_sel` is captured on the first clock edge after reset release. Later changes to it have no effect until the next reset.
- R3: Route codes are 2'b00 off, 2'b01 maskable and 2'b10 non-maskable; 2'b11 acts as off. When routing is off, field sync sets no status bit, raises no `irq_o` and raises no `nmi_o`.
- R4: In non-maskable routing, each rising edge of `fsync` seen at a clock edge drives `nmi_o` high for exactly the following cycle. A sync held high gives one pulse. Status bit 1 never sets in this routing.
- R5: In maskable routing, a rising edge of `fsync` sets status bit 1 at that clock edge.
- R6: `io_done` high at a clock edge sets status bit 0 at that edge.
- R7: Status reads at offset 0x11 with bit 0 = completion and bit 1 = frame, upper bits zero. Writes to 0x11 are ignored.
- R8: Enable at offset 0x12 is a full 8-bit read/write register. Only bits [1:0] gate the matching status bits.
- R9: Writing 0x13 clears every status bit whose data bit is 1. A set event in the same cycle wins over the clear. Offset 0x13 reads zero.
- R10: `irq_o` is high exactly when status AND enable[1:0] is nonzero, updated at the same edge as the registers.
- R11: Reads return data in the same cycle. Unused offsets read zero and ignore writes. `bus_rdata` is zero when no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| route_sel | input | 2 | Field-sync routing strap |
| fsync | input | 1 | Video field-sync level |
| io_done | input | 1 | Host-service completion strobe |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset in the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| irq_o | output | 1 | Maskable interrupt, level |
| nmi_o | output | 1 | Non-maskable interrupt, one-cycle pulse |

## Verification
A wrong status or enable bit shows up on `irq_o` at the very next clock edge. It also shows in the read of 0x11 or 0x12 during the following cycle. A wrong captured routing mode shows at the next field-sync rising edge: an `nmi_o` pulse is missing or appears where none should, or status bit 1 is wrongly set or left clear. A broken edge detector produces a second `nmi_o` cycle while sync stays high, and this is visible one cycle after the first pulse.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int N_SRC  = 2;
  localparam int SRC_IO    = 0;
  localparam int SRC_FRAME = 1;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h11;
  localparam logic [ADDR_W-1:0] OFF_EN   = 5'h12;
  localparam logic [ADDR_W-1:0] OFF_ACK  = 5'h13;

  typedef enum logic [1:0] {
    RT_OFF  = 2'b00,
    RT_MASK = 2'b01,
    RT_NMI  = 2'b10,
    RT_RSVD = 2'b11
  } route_e;
endpackage

// File: rtl/irq_frame_route.sv
module irq_frame_route
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] route_sel,
  input  logic       fsync,
  output logic       frame_set,
  output logic       nmi_o
);
  logic   armed;
  logic   fs_q;
  logic   nmi_q;
  route_e mode_q;
  logic   rise;

  assign rise = fsync & ~fs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      fs_q   <= 1'b0;
      nmi_q  <= 1'b0;
      mode_q <= RT_OFF;
    end else begin
      fs_q  <= fsync;
      nmi_q <= rise && (mode_q == RT_NMI);
      if (!armed) begin
        armed  <= 1'b1;
        mode_q <= (route_sel == RT_RSVD) ? RT_OFF : route_e'(route_sel);
      end
    end
  end

  assign frame_set = rise && (mode_q == RT_MASK);
  assign nmi_o     = nmi_q;

  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |=> !nmi_q); // R4
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(armed)) |-> $stable(mode_q)); // R2
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RT_OFF) |=> !nmi_q); // R3
  AST_NMI_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RT_NMI) |-> !frame_set); // R4
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_route_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  input  logic          en_wr,
  input  logic [DW-1:0] en_wdata,
  output logic [NS-1:0] stat_o,
  output logic [DW-1:0] en_o,
  output logic          irq_o
);
  logic [NS-1:0] stat_q;
  logic [DW-1:0] en_q;

  for (genvar i = 0; i < NS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[i] <= 1'b0;
      else        stat_q[i] <= set_i[i] | (stat_q[i] & ~clr_i[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata;
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
  assign irq_o  = |(stat_q & en_q[NS-1:0]);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i))); // R9
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0)); // R9
endmodule

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_route_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NS = N_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NS-1:0] stat,
  input  logic [DW-1:0] en,
  output logic          en_wr,
  output logic [DW-1:0] en_wdata,
  output logic [NS-1:0] clr,
  output logic [DW-1:0] rdata
);
  localparam int PAD = DW - NS;
  logic rd;
  assign rd       = sel && !we;
  assign en_wr    = sel && we && (addr == OFF_EN);
  assign en_wdata = wdata;
  assign clr      = (sel && we && (addr == OFF_ACK)) ? wdata[NS-1:0] : '0;

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (addr == OFF_STAT)    rdata = {{PAD{1'b0}}, stat};
      else if (addr == OFF_EN) rdata = en;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> (rdata == '0)); // R11
  AST_STAT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFF_STAT) |-> (rdata[DW-1:NS] == '0)); // R7
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    route_sel,
  input  logic          fsync,
  input  logic          io_done,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          nmi_o
);
  logic              frame_set;
  logic [N_SRC-1:0]  set_v;
  logic [N_SRC-1:0]  clr_v;
  logic [N_SRC-1:0]  stat_v;
  logic [DW-1:0]     en_v;
  logic [DW-1:0]     en_wdata;
  logic              en_wr;

  irq_frame_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .route_sel (route_sel),
    .fsync     (fsync),
    .frame_set (frame_set),
    .nmi_o     (nmi_o)
  );

  always_comb begin
    set_v            = '0;
    set_v[SRC_IO]    = io_done;
    set_v[SRC_FRAME] = frame_set;
  end

  irq_stat_bank #(.NS(N_SRC), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_v),
    .clr_i    (clr_v),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .stat_o   (stat_v),
    .en_o     (en_v),
    .irq_o    (irq_o)
  );

  irq_bus_decode #(.AW(AW), .DW(DW), .NS(N_SRC)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .stat     (stat_v),
    .en       (en_v),
    .en_wr    (en_wr),
    .en_wdata (en_wdata),
    .clr      (clr_v),
    .rdata    (bus_rdata)
  );

  AST_IO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    io_done |=> stat_v[SRC_IO]); // R6
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] route_sel = 2'b00;
  logic       fsync = 1'b0, io_done = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o, nmi_o;

  always #5 clk = ~clk;

  irq_route_ctrl u0 (.*);

  int n_run = 0, n_fail = 0;
  logic [1:0] m_stat; logic [7:0] m_en; logic [1:0] m_mode;
  logic m_armed, m_fsp, m_nmi;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic s, input logic w, input logic [4:0] a);
    if (!s || w) return 8'h00;
    if (a == 5'h11) return {6'b0, m_stat};
    if (a == 5'h12) return m_en;
    return 8'h00;
  endfunction

  function automatic logic [1:0] norm(input logic [1:0] r);
    return (r == 2'b11) ? 2'b00 : r;
  endfunction

  task automatic do_reset(input logic [1:0] rs);
    @(negedge clk);
    rst_n = 1'b0; route_sel = rs; fsync = 0; io_done = 0; bus_sel = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(irq_o == 0 && nmi_o == 0 && bus_rdata == 0, "R1 outputs in reset",
        {irq_o, nmi_o}, 0);
    rst_n = 1'b1;
    m_stat = 0; m_en = 0; m_mode = 0; m_armed = 0; m_fsp = 0; m_nmi = 0;
  endtask

  task automatic cyc(input logic s, input logic w, input logic [4:0] a,
                     input logic [7:0] d, input logic fs, input logic dn);
    logic rise; logic [1:0] clr;
    @(negedge clk);
    bus_sel = s; bus_we = w; bus_addr = a; bus_wdata = d; fsync = fs; io_done = dn;
    #1;
    chk(bus_rdata == exp_rd(s, w, a), "R11/R7/R8/R9 read data", bus_rdata, exp_rd(s, w, a));
    @(posedge clk);
    rise = fs & ~m_fsp;
    clr = (s && w && a == 5'h13) ? d[1:0] : 2'b00;
    m_stat = (m_stat & ~clr) | {rise && m_mode == 2'b01, dn};
    if (s && w && a == 5'h12) m_en = d;
    m_nmi = rise && m_mode == 2'b10;
    m_fsp = fs;
    if (!m_armed) begin m_armed = 1; m_mode = norm(route_sel); end
    #2;
    chk(irq_o == |(m_stat & m_en[1:0]), "R10 irq level", irq_o, |(m_stat & m_en[1:0]));
    chk(nmi_o == m_nmi, "R4/R3 nmi", nmi_o, m_nmi);
  endtask

  task automatic idle(input int n, input logic fs);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, fs, 0);
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [4:0] a; int k;
      k = $urandom_range(0, 9);
      a = (k < 3) ? 5'h11 : (k < 5) ? 5'h12 : (k < 7) ? 5'h13 : 5'($urandom);
      cyc($urandom_range(0, 1), $urandom_range(0, 1), a, 8'($urandom),
          $urandom_range(0, 3) == 0, $urandom_range(0, 7) == 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state, then read after release
    do_reset(2'b00);
    cyc(1, 0, 5'h11, 0, 0, 0);
    cyc(1, 0, 5'h12, 0, 0, 0);
    chk(irq_o == 0 && nmi_o == 0, "R1 after release", {irq_o, nmi_o}, 0);

    // R3: off mode, sync edges do nothing; R6 completion still latches
    cyc(1, 1, 5'h12, 8'hFF, 0, 0);
    cyc(0, 0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 0, 5'h11, 0, 0, 0);
    chk(irq_o == 0, "R3 off mode no irq", irq_o, 0);
    cyc(0, 0, 0, 0, 0, 1);
    chk(irq_o == 1, "R6 completion raises irq", irq_o, 1);
    // R7: write to status ignored; R9 ack clears
    cyc(1, 1, 5'h11, 8'h00, 0, 0);
    cyc(1, 0, 5'h11, 0, 0, 0);
    cyc(1, 1, 5'h13, 8'h01, 0, 0);
    chk(irq_o == 0, "R9 ack clears", irq_o, 0);
    // R11: unused offsets ignore writes
    cyc(1, 1, 5'h05, 8'hAA, 0, 0);
    cyc(1, 0, 5'h05, 0, 0, 0);
    cyc(1, 0, 5'h13, 0, 0, 0);
    rand_run(1500);

    // R3: reserved code behaves as off
    do_reset(2'b11);
    cyc(1, 1, 5'h12, 8'h03, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    cyc(1, 0, 5'h11, 0, 0, 0);
    rand_run(800);

    // R5: maskable routing; R9 set wins over ack in same cycle
    do_reset(2'b01);
    cyc(1, 1, 5'h12, 8'h02, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk(irq_o == 1, "R5 frame sets status", irq_o, 1);
    cyc(1, 1, 5'h13, 8'h02, 0, 0);
    cyc(1, 1, 5'h13, 8'h02, 1, 0);
    chk(irq_o == 1, "R9 set wins over ack", irq_o, 1);
    // R8: enable bit 1 cleared masks it; scratch bits read back
    cyc(1, 1, 5'h12, 8'hF1, 0, 0);
    chk(irq_o == 0, "R8 mask gates irq", irq_o, 0);
    cyc(1, 0, 5'h12, 0, 0, 0);
    // R2: strap change after capture ignored
    route_sel = 2'b10;
    cyc(1, 1, 5'h13, 8'h03, 0, 0);
    idle(2, 0); idle(1, 1);
    chk(nmi_o == 0, "R2 strap change ignored", nmi_o, 0);
    rand_run(1500);

    // R4: NMI routing, held sync gives one pulse
    do_reset(2'b10);
    cyc(1, 1, 5'h12, 8'h03, 0, 0);
    cyc(0, 0, 0, 0, 1, 0);
    chk(nmi_o == 1, "R4 nmi pulse", nmi_o, 1);
    idle(5, 1);
    chk(nmi_o == 0, "R4 held sync single pulse", nmi_o, 0);
    cyc(1, 0, 5'h11, 0, 0, 0);
    route_sel = 2'b00;
    idle(1, 0); idle(1, 1);
    chk(nmi_o == 1, "R2 captured NMI mode kept", nmi_o, 1);
    rand_run(1500);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule